// File: doc/BRIEF.md
# One-Shot Pulse Down-Counter Bank

A bank of sixteen independent single-pulse generators. Each channel owns a 16-bit down-counter, a start (busy) bit, an output line and a completion flag. Software writes a count into an idle channel's counter and then sets that channel's start bit. On that clock edge the output rises. The counter then loses one per clock. When it reaches zero the channel stops by itself, drops its output, clears its start bit and raises its completion flag. The result is a pulse exactly as many clocks long as the loaded count.

All access goes through one write port and a combinational read port. The counters sit at addresses 0 to NCH-1. Address NCH holds the start bits: writing a 1 starts that channel, and reading returns the busy bits. Address NCH+1 holds the completion flags: reading returns them, and writing a 1 clears a flag. Address NCH+2 holds the per-channel interrupt enables, and it reads back the same way. A single interrupt line is the OR of the enabled flags.

Top module: `oneshot_bank`

## Requirements
- R1: After reset all counters read 0, start bits, flags and enables read 0, every pulse output is 0 and irq_o is 0.
- R2: A write to address i (0..NCH-1) while channel i is idle loads its counter, and a read of address i returns it.
- R3: Writing 1 to bit i at address NCH while channel i is idle with count N>0 raises pulse_o[i] after that edge. The pulse stays high for exactly N clocks.
- R4: When the count reaches 0, pulse_o[i] falls, counter i reads 0, start bit i reads 0 and flag i (address NCH+1, bit i) reads 1, all in the same cycle.
- R5: A counter write while the channel runs is ignored: the pulse length and the countdown are unchanged.
- R6: Starting a channel whose counter holds 0 gives no pulse, but flag i is set on that edge.
- R7: Writing 1 to bit i at address NCH+1 clears flag i. Writing 0 to a bit leaves that flag set.
- R8: irq_o is 1 exactly when some channel has both its flag and its enable (address NCH+2, bit i) set.
- R9: Channels are independent. A 0 bit in a start write does not affect that channel, and channels started together end after their own counts.
- R10: A start write to a running channel is ignored: no retrigger and no change in pulse length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| pulse_o | output | 16 | One-shot pulse outputs, one per channel |
| irq_o | output | 1 | OR of enabled completion flags |

## Verification
A write takes effect on the edge that samples it, and the bench drives and samples on falling edges. A loaded counter therefore reads back on the next falling edge, and a started pulse is already high there. The pulse is measured by counting the falling edges on which it is high, and the count must equal N. Flag, busy bit and counter are read at the first falling edge after the pulse drops, because all three settle on the same edge. Reads and irq_o are combinational, so they are checked in the same half cycle their inputs change.

// File: rtl/oneshot_bank.sv
module oneshot_bank #(
  parameter int NCH = 16,
  parameter int CW  = 16
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       bus_we,
  input  logic [$clog2(NCH+3)-1:0]                   bus_addr,
  input  logic [((CW > NCH) ? CW : NCH)-1:0]         bus_wdata,
  output logic [((CW > NCH) ? CW : NCH)-1:0]         bus_rdata,
  output logic [NCH-1:0]                             pulse_o,
  output logic                                       irq_o
);
  localparam int DW = (CW > NCH) ? CW : NCH;
  localparam int AW = $clog2(NCH+3);
  localparam logic [AW-1:0] A_START = AW'(NCH);
  localparam logic [AW-1:0] A_FLAG  = AW'(NCH + 1);
  localparam logic [AW-1:0] A_IEN   = AW'(NCH + 2);

  logic [NCH-1:0] run_q, flag_q, ien_q;
  logic [CW-1:0]  cnt_q [NCH];

  wire wr_start = bus_we && (bus_addr == A_START);
  wire wr_flag  = bus_we && (bus_addr == A_FLAG);
  wire wr_ien   = bus_we && (bus_addr == A_IEN);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    wire ld   = bus_we && (bus_addr == AW'(ch));
    wire go   = wr_start && bus_wdata[ch] && !run_q[ch];
    wire last = run_q[ch] && (cnt_q[ch] == CW'(1));
    wire done = last || (go && (cnt_q[ch] == '0));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[ch] <= '0;
        run_q[ch] <= 1'b0;
      end else if (run_q[ch]) begin
        cnt_q[ch] <= cnt_q[ch] - CW'(1);
        if (last) run_q[ch] <= 1'b0;
      end else if (go) begin
        run_q[ch] <= (cnt_q[ch] != '0);
      end else if (ld) begin
        cnt_q[ch] <= bus_wdata[CW-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                        flag_q[ch] <= 1'b0;
      else if (done)                     flag_q[ch] <= 1'b1;
      else if (wr_flag && bus_wdata[ch]) flag_q[ch] <= 1'b0;
    end

    p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[ch] && cnt_q[ch] > CW'(1)) |=> (run_q[ch] && cnt_q[ch] == $past(cnt_q[ch]) - CW'(1)));
    p_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[ch] && cnt_q[ch] == CW'(1)) |=> (!run_q[ch] && flag_q[ch] && cnt_q[ch] == '0));
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[ch] && !(bus_we && bus_addr == AW'(ch))) |=> $stable(cnt_q[ch]));
    p_zero_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start && bus_wdata[ch] && !run_q[ch] && cnt_q[ch] == '0) |=> (flag_q[ch] && !run_q[ch]));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && bus_wdata[ch] && !run_q[ch]) |=> !flag_q[ch]);
    p_no_retrig_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[ch] && cnt_q[ch] > CW'(1) && wr_start) |=> run_q[ch]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= bus_wdata[NCH-1:0];
  end

  assign pulse_o = run_q;
  assign irq_o   = |(flag_q & ien_q);

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (bus_addr == AW'(i)) bus_rdata = DW'(cnt_q[i]);
    if (bus_addr == A_START) bus_rdata = DW'(run_q);
    if (bus_addr == A_FLAG)  bus_rdata = DW'(flag_q);
    if (bus_addr == A_IEN)   bus_rdata = DW'(ien_q);
  end
endmodule

// File: tb/tb_oneshot_bank.sv
module tb_oneshot_bank;
  localparam int TCLK = 10;
  localparam int NCH = 16;
  localparam logic [4:0] A_START = 5'd16, A_FLAG = 5'd17, A_IEN = 5'd18;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, pulse_o;
  logic irq_o;
  int checks = 0, errors = 0;

  oneshot_bank dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
                    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pulse_o(pulse_o), .irq_o(irq_o));

  always #(TCLK/2) clk = ~clk;

  localparam int NV = 6;
  localparam int VCH [NV] = '{0, 3, 7, 9, 12, 15};
  localparam int VCNT[NV] = '{1, 2, 5, 17, 300, 1000};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd(logic [4:0] a, output int v);
    bus_addr = a; #1; v = int'(bus_rdata);
  endtask

  task automatic width(int ch, output int w);
    w = 0;
    while (pulse_o[ch] && w < 70000) begin w++; @(negedge clk); end
  endtask

  initial begin
    int v, w;
    @(negedge clk); @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R1 reset state
    chk("R1 pulse", int'(pulse_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    rd(5'd4, v);   chk("R1 counter", v, 0);
    rd(A_START, v); chk("R1 start", v, 0);
    rd(A_FLAG, v);  chk("R1 flag", v, 0);
    rd(A_IEN, v);   chk("R1 ien", v, 0);

    for (int k = 0; k < NV; k++) begin
      wr(5'(VCH[k]), 16'(VCNT[k]));
      rd(5'(VCH[k]), v); chk("R2 load", v, VCNT[k]);
      wr(A_START, 16'(1 << VCH[k]));
      chk("R3 rise", int'(pulse_o[VCH[k]]), 1);
      width(VCH[k], w); chk("R3 width", w, VCNT[k]);
      rd(5'(VCH[k]), v); chk("R4 counter zero", v, 0);
      rd(A_START, v);    chk("R4 busy clear", v, 0);
      rd(A_FLAG, v);     chk("R4 flag", v, 1 << VCH[k]);
      wr(A_FLAG, 16'(1 << VCH[k]));
      rd(A_FLAG, v);     chk("R7 cleared", v, 0);
    end

    // R5 counter write during run ignored
    wr(5'd1, 16'd10); wr(A_START, 16'h0002);
    wr(5'd1, 16'd500);
    width(1, w); chk("R5 width", w, 9);
    rd(5'd1, v); chk("R5 counter", v, 0);

    // R10 start while running ignored
    wr(5'd2, 16'd8); wr(A_START, 16'h0004);
    wr(A_START, 16'h0004); wr(A_START, 16'h0004);
    width(2, w); chk("R10 width", w, 6);

    // R6 zero start
    wr(A_FLAG, 16'hFFFF);
    wr(A_START, 16'h0040);
    chk("R6 no pulse", int'(pulse_o), 0);
    rd(A_FLAG, v); chk("R6 flag", v, 16'h0040);

    // R7 writing 0 keeps flag
    wr(A_FLAG, 16'hFFBF);
    rd(A_FLAG, v); chk("R7 zero write keeps", v, 16'h0040);

    // R8 interrupt gating
    chk("R8 irq masked", int'(irq_o), 0);
    wr(A_IEN, 16'h0040); chk("R8 irq enabled", int'(irq_o), 1);
    rd(A_IEN, v); chk("R8 ien readback", v, 16'h0040);
    wr(A_IEN, 16'h0080); chk("R8 other enable", int'(irq_o), 0);
    wr(A_IEN, 16'h0040); wr(A_FLAG, 16'h0040); chk("R8 irq after clear", int'(irq_o), 0);

    // R9 independence
    wr(5'd5, 16'd3); wr(5'd11, 16'd7);
    wr(A_START, 16'h0820);
    chk("R9 both high", int'(pulse_o), 16'h0820);
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R9 ch5 done ch11 running", int'(pulse_o), 16'h0800);
    rd(A_FLAG, v); chk("R9 flag ch5 only", v, 16'h0020);
    wr(A_START, 16'h0000);
    chk("R9 zero start bits", int'(pulse_o), 16'h0800);
    width(11, w); chk("R9 ch11 remaining", w, 3);
    rd(A_FLAG, v); chk("R9 both flags", v, 16'h0820);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule